// File: doc/BRIEF.md
# Power-Mode Sequencer

This block sequences the power state of a microcontroller's clock and power unit. It holds the current operating mode: a run mode and four low-power modes (doze, sleep, deep-sleep and power-down). From that mode it derives the clock divider that is in use and a set of clock and supply gating enables. In run and doze the clock can sit in a fast substate or a slow substate, and each substate has its own divider value that software programs.

Software drives the block through a small register write port with two targets. The control target carries the requested mode, a lock bit that bars entry to low-power modes, a clock-source select, the slow-substate select and a write-one-to-clear strobe for a sticky "request refused" flag. The divider target carries the fast and slow divider values. A processor power-enable input must be high for entry to be allowed. A wake input returns the block to run mode with the fast substate selected, the same state it takes after reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: After synchronous reset the mode is run (code 000), the fast substate is selected (lo_state_o=0), div_o equals the fast divider reset value, gate_en_o=4'b1111, rejected_o=0, lock_o=0 and clksrc_o=0.
- R2: Mode codes are 000 run, 001 doze, 010 sleep, 011 deep-sleep, 100 power-down; a control write carrying 101, 110 or 111 leaves the mode unchanged and does not set rejected_o.
- R3: With wr_sel_i=0 a write loads the control fields: bits [2:0] mode request, bit 3 lock, bit 4 clock-source select, bit 5 slow substate, bit 6 write-one-to-clear of rejected_o. With wr_sel_i=1, bits [DIV_W-1:0] load the fast divider and bits [2*DIV_W-1:DIV_W] load the slow divider. Every write shows at the outputs right after the clock edge that captures it.
- R4: exit_i=1 puts the block in run mode with the fast substate at the next edge, and a control write in the same cycle is discarded as a whole.
- R5: A low-power request is accepted only while pwr_en_i=1 and the lock bit, as held before that write, is 0.
- R6: Low-power requests are acted on only from run mode; in any low-power mode the mode field of a write has no effect, and only exit_i leaves that mode.
- R7: In doze the mode field and clock-source bit of a control write are ignored and keep their values, while the lock and slow-substate bits are still written.
- R8: A low-power request made in run mode while entry is barred leaves the mode unchanged and sets rejected_o. The flag stays set until a control write has bit 6 at 1. If a refusal and a clear fall in the same write, the flag is set.
- R9: div_o is the fast divider in run or doze with the fast substate, the slow divider in run or doze with the slow substate, and 0 in sleep, deep-sleep and power-down.
- R10: gate_en_o = {oscillator, PLL, peripheral clock, core clock} is 1111 in run, 1110 in doze, 1100 in sleep, 1000 in deep-sleep and 0000 in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_en_i | input | 1 | Processor power-enable; must be 1 for low-power entry |
| exit_i | input | 1 | Wake request; returns to run mode, fast substate |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 dividers |
| wr_data_i | input | DATA_W | Write data |
| mode_o | output | 3 | Current mode code |
| lo_state_o | output | 1 | 1 when the slow substate is selected |
| div_o | output | DIV_W | Active divider value |
| gate_en_o | output | 4 | Gating enables {osc, pll, periph, core} |
| clksrc_o | output | 1 | Clock-source select |
| lock_o | output | 1 | Low-power entry lock |
| rejected_o | output | 1 | Sticky flag for a refused low-power request |

## Verification
Two pairs of functions can fall in one cycle. The first is a wake request with a control write that asks for a new mode or clears the refusal flag. The second is a refused entry request whose write also carries the clear strobe. The bench drives both pairs in single vectors. It then checks that the wake wins with the whole write dropped (mode run, fast substate, flag kept), and that the flag ends up set when refusal and clearing coincide. A further vector enters doze with the lock bit set in the same write, which shows that the lock value held before the write is the one that decides entry.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    MODE_RUN   = 3'b000,
    MODE_DOZE  = 3'b001,
    MODE_SLEEP = 3'b010,
    MODE_DEEP  = 3'b011,
    MODE_OFF   = 3'b100
  } pmode_e;

  // Control write field positions
  localparam int CTL_MODE_LSB = 0;
  localparam int CTL_MODE_W   = 3;
  localparam int CTL_LOCK_BIT = 3;
  localparam int CTL_CLK_BIT  = 4;
  localparam int CTL_LO_BIT   = 5;
  localparam int CTL_RCLR_BIT = 6;
  localparam int CTL_MIN_W    = 7;

  // Number of gating enables; bit i stays on while the mode rank is <= i
  localparam int GATE_N = 4;

  function automatic logic is_lp_code(input logic [2:0] code);
    return (code != 3'b000) && (code <= 3'b100);
  endfunction

  function automatic logic is_fast_clk_mode(input pmode_e m);
    return (m == MODE_RUN) || (m == MODE_DOZE);
  endfunction

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        exit_req,
  input  logic        ctrl_we,
  input  logic [2:0]  mode_wr,
  input  logic        lo_wr,
  input  logic        pwr_en,
  input  logic        lock_q,
  output pmode_e      mode_q,
  output pmode_e      mode_d,
  output logic        lo_q,
  output logic        lo_d,
  output logic        reject_set
);

  logic entry_ok;
  logic req_lp;

  assign entry_ok = pwr_en & ~lock_q;
  assign req_lp   = is_lp_code(mode_wr);

  always_comb begin
    mode_d     = mode_q;
    lo_d       = lo_q;
    reject_set = 1'b0;
    if (exit_req) begin
      mode_d = MODE_RUN;
      lo_d   = 1'b0;
    end else if (ctrl_we) begin
      lo_d = lo_wr;
      if (mode_q == MODE_RUN && req_lp) begin
        if (entry_ok) begin
          mode_d = pmode_e'(mode_wr);
        end else begin
          reject_set = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RUN;
      lo_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lo_q   <= lo_d;
    end
  end

endmodule

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_pkg::*;
#(
  parameter int          DIV_W      = 4,
  parameter int          DATA_W     = 8,
  parameter logic [DIV_W-1:0] DIV_HI_RST = 1,
  parameter logic [DIV_W-1:0] DIV_LO_RST = 8,
  parameter logic        LOCK_RST   = 1'b0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              div_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_doze,
  input  logic              reject_set,
  output logic              lock_q,
  output logic              clksrc_q,
  output logic              rej_q,
  output logic [DIV_W-1:0]  div_hi_d,
  output logic [DIV_W-1:0]  div_lo_d
);

  localparam int HI_LSB = 0;
  localparam int LO_LSB = DIV_W;

  logic [DIV_W-1:0] div_hi_q;
  logic [DIV_W-1:0] div_lo_q;
  logic             lock_d;
  logic             clksrc_d;
  logic             rej_d;

  always_comb begin
    lock_d   = lock_q;
    clksrc_d = clksrc_q;
    rej_d    = rej_q;
    if (ctrl_we) begin
      lock_d = wr_data[CTL_LOCK_BIT];
      if (!in_doze) begin
        clksrc_d = wr_data[CTL_CLK_BIT];
      end
      if (wr_data[CTL_RCLR_BIT]) begin
        rej_d = 1'b0;
      end
    end
    if (reject_set) begin
      rej_d = 1'b1;
    end
  end

  always_comb begin
    div_hi_d = div_hi_q;
    div_lo_d = div_lo_q;
    if (div_we) begin
      div_hi_d = wr_data[HI_LSB +: DIV_W];
      div_lo_d = wr_data[LO_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q   <= LOCK_RST;
      clksrc_q <= 1'b0;
      rej_q    <= 1'b0;
      div_hi_q <= DIV_HI_RST;
      div_lo_q <= DIV_LO_RST;
    end else begin
      lock_q   <= lock_d;
      clksrc_q <= clksrc_d;
      rej_q    <= rej_d;
      div_hi_q <= div_hi_d;
      div_lo_q <= div_lo_d;
    end
  end

endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
  import pwr_pkg::*;
#(
  parameter int               DIV_W      = 4,
  parameter logic [DIV_W-1:0] DIV_HI_RST = 1
)(
  input  logic              clk,
  input  logic              rst,
  input  pmode_e            mode_d,
  input  logic              lo_d,
  input  logic [DIV_W-1:0]  div_hi_d,
  input  logic [DIV_W-1:0]  div_lo_d,
  output logic [DIV_W-1:0]  div_o,
  output logic [GATE_N-1:0] gate_o
);

  logic [DIV_W-1:0] div_sel;

  always_comb begin
    if (!is_fast_clk_mode(mode_d)) begin
      div_sel = '0;
    end else if (lo_d) begin
      div_sel = div_lo_d;
    end else begin
      div_sel = div_hi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o <= DIV_HI_RST;
    end else begin
      div_o <= div_sel;
    end
  end

  // Deeper modes have larger codes; each enable drops out once the rank passes it
  for (genvar gi = 0; gi < GATE_N; gi++) begin : g_gate
    localparam logic [2:0] RANK_MAX = 3'(gi);
    always_ff @(posedge clk) begin
      if (rst) begin
        gate_o[gi] <= 1'b1;
      end else begin
        gate_o[gi] <= (mode_d <= RANK_MAX);
      end
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int               DIV_W      = 4,
  parameter int               DATA_W     = 8,
  parameter logic [DIV_W-1:0] DIV_HI_RST = 1,
  parameter logic [DIV_W-1:0] DIV_LO_RST = 8,
  parameter logic             LOCK_RST   = 1'b0
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_en_i,
  input  logic              exit_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [2:0]        mode_o,
  output logic              lo_state_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [3:0]        gate_en_o,
  output logic              clksrc_o,
  output logic              lock_o,
  output logic              rejected_o
);

  // DATA_W must cover both the control fields and two divider fields
  localparam int NEED_W = (2 * DIV_W > CTL_MIN_W) ? 2 * DIV_W : CTL_MIN_W;
  if (DATA_W < NEED_W) begin : g_bad_width
    initial $error("pwr_mode_seq: DATA_W too small");
  end

  logic             ctrl_we;
  logic             div_we;
  pmode_e           mode_q;
  pmode_e           mode_d;
  logic             lo_q;
  logic             lo_d;
  logic             reject_set;
  logic             lock_q;
  logic             clksrc_q;
  logic             rej_q;
  logic [DIV_W-1:0] div_hi_d;
  logic [DIV_W-1:0] div_lo_d;

  assign ctrl_we = wr_en_i & ~wr_sel_i & ~exit_i;
  assign div_we  = wr_en_i &  wr_sel_i;

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .exit_req   (exit_i),
    .ctrl_we    (ctrl_we),
    .mode_wr    (wr_data_i[CTL_MODE_LSB +: CTL_MODE_W]),
    .lo_wr      (wr_data_i[CTL_LO_BIT]),
    .pwr_en     (pwr_en_i),
    .lock_q     (lock_q),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .lo_q       (lo_q),
    .lo_d       (lo_d),
    .reject_set (reject_set)
  );

  pwr_cfg_regs #(
    .DIV_W      (DIV_W),
    .DATA_W     (DATA_W),
    .DIV_HI_RST (DIV_HI_RST),
    .DIV_LO_RST (DIV_LO_RST),
    .LOCK_RST   (LOCK_RST)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .div_we     (div_we),
    .wr_data    (wr_data_i),
    .in_doze    (mode_q == MODE_DOZE),
    .reject_set (reject_set),
    .lock_q     (lock_q),
    .clksrc_q   (clksrc_q),
    .rej_q      (rej_q),
    .div_hi_d   (div_hi_d),
    .div_lo_d   (div_lo_d)
  );

  pwr_out_stage #(
    .DIV_W      (DIV_W),
    .DIV_HI_RST (DIV_HI_RST)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .mode_d   (mode_d),
    .lo_d     (lo_d),
    .div_hi_d (div_hi_d),
    .div_lo_d (div_lo_d),
    .div_o    (div_o),
    .gate_o   (gate_en_o)
  );

  assign mode_o     = mode_q;
  assign lo_state_o = lo_q;
  assign clksrc_o   = clksrc_q;
  assign lock_o     = lock_q;
  assign rejected_o = rej_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int DIV_W  = 4,
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rst,
  input logic              pwr_en_i,
  input logic              exit_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [2:0]        mode_o,
  input logic              lo_state_o,
  input logic [DIV_W-1:0]  div_o,
  input logic [3:0]        gate_en_o,
  input logic              clksrc_o,
  input logic              lock_o,
  input logic              rejected_o
);

  AST_EXIT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    exit_i |=> (mode_o == 3'b000 && !lo_state_o)); // R4

  AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 3'b000 && $past(mode_o) == 3'b000) |-> ($past(pwr_en_i) && !$past(lock_o))); // R5

  AST_LP_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> ($past(mode_o) == 3'b000 || mode_o == 3'b000)); // R6

  AST_DOZE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 3'b001 && !$past(exit_i)) |-> ($stable(clksrc_o) && mode_o == 3'b001)); // R7

  AST_REJ_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(rejected_o) && !($past(wr_en_i) && !$past(wr_sel_i) && $past(wr_data_i[6]) && !$past(exit_i)))
      |-> rejected_o); // R8

  AST_STOPPED_DIV: assert property (@(posedge clk) disable iff (rst)
    (mode_o > 3'b001) |-> (div_o == '0)); // R9

  AST_CORE_GATE: assert property (@(posedge clk) disable iff (rst)
    gate_en_o[0] == (mode_o == 3'b000)); // R10

  AST_GATE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_en_o) == 4 - int'(mode_o)); // R10

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_en_i   (pwr_en_i),
  .exit_i     (exit_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .mode_o     (mode_o),
  .lo_state_o (lo_state_o),
  .div_o      (div_o),
  .gate_en_o  (gate_en_o),
  .clksrc_o   (clksrc_o),
  .lock_o     (lock_o),
  .rejected_o (rejected_o)
);

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

  localparam int DIV_W  = 4;
  localparam int DATA_W = 8;
  localparam int NVEC   = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pwr_en_i = 1'b0;
  logic              exit_i = 1'b0;
  logic              wr_en_i = 1'b0;
  logic              wr_sel_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [2:0]        mode_o;
  logic              lo_state_o;
  logic [DIV_W-1:0]  div_o;
  logic [3:0]        gate_en_o;
  logic              clksrc_o;
  logic              lock_o;
  logic              rejected_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.DIV_W(DIV_W), .DATA_W(DATA_W), .DIV_HI_RST(4'd1), .DIV_LO_RST(4'd8)) u0 (
    .clk(clk), .rst(rst), .pwr_en_i(pwr_en_i), .exit_i(exit_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .mode_o(mode_o), .lo_state_o(lo_state_o),
    .div_o(div_o), .gate_en_o(gate_en_o), .clksrc_o(clksrc_o), .lock_o(lock_o),
    .rejected_o(rejected_o)
  );

  // {mode, lo, div, gate, rej, clksrc, lock}
  typedef struct packed {
    logic       ex;
    logic       pe;
    logic       we;
    logic       sel;
    logic [7:0] d;
    logic [2:0] m;
    logic       lo;
    logic [3:0] dv;
    logic [3:0] g;
    logic       rj;
    logic       ck;
    logic       lk;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VT [NVEC] = '{
    '{1'b0,1'b1,1'b1,1'b1,8'h52, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd3},  // R3 divider load
    '{1'b0,1'b1,1'b1,1'b0,8'h20, 3'd0,1'b1,4'd5,4'hF,1'b0,1'b0,1'b0, 8'd9},  // R9 slow substate
    '{1'b0,1'b0,1'b1,1'b0,8'h21, 3'd0,1'b1,4'd5,4'hF,1'b1,1'b0,1'b0, 8'd8},  // R8 refused, no power-enable
    '{1'b0,1'b1,1'b1,1'b0,8'h29, 3'd1,1'b1,4'd5,4'hE,1'b1,1'b0,1'b1, 8'd5},  // R5 old lock decides
    '{1'b0,1'b1,1'b1,1'b0,8'h12, 3'd1,1'b0,4'd2,4'hE,1'b1,1'b0,1'b0, 8'd7},  // R7 doze hold
    '{1'b1,1'b1,1'b1,1'b0,8'h42, 3'd0,1'b0,4'd2,4'hF,1'b1,1'b0,1'b0, 8'd4},  // R4 exit beats write
    '{1'b0,1'b1,1'b1,1'b0,8'h40, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd8},  // R8 clear
    '{1'b0,1'b1,1'b1,1'b0,8'h02, 3'd2,1'b0,4'd0,4'hC,1'b0,1'b0,1'b0, 8'd10}, // R10 sleep
    '{1'b0,1'b1,1'b1,1'b0,8'h03, 3'd2,1'b0,4'd0,4'hC,1'b0,1'b0,1'b0, 8'd6},  // R6 no hop
    '{1'b1,1'b1,1'b0,1'b0,8'h00, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd4},  // R4 wake
    '{1'b0,1'b1,1'b1,1'b0,8'h07, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd2},  // R2 reserved code
    '{1'b0,1'b1,1'b1,1'b0,8'h08, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b1, 8'd3},  // R3 lock set
    '{1'b0,1'b1,1'b1,1'b0,8'h03, 3'd0,1'b0,4'd2,4'hF,1'b1,1'b0,1'b0, 8'd5},  // R5 locked refuse
    '{1'b0,1'b1,1'b1,1'b0,8'h43, 3'd3,1'b0,4'd0,4'h8,1'b0,1'b0,1'b0, 8'd10}, // R10 deep-sleep
    '{1'b1,1'b1,1'b0,1'b0,8'h00, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd4},  // R4
    '{1'b0,1'b1,1'b1,1'b0,8'h44, 3'd4,1'b0,4'd0,4'h0,1'b0,1'b0,1'b0, 8'd10}, // R10 power-down
    '{1'b1,1'b1,1'b0,1'b0,8'h00, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b0,1'b0, 8'd4},  // R4
    '{1'b0,1'b1,1'b1,1'b0,8'h10, 3'd0,1'b0,4'd2,4'hF,1'b0,1'b1,1'b0, 8'd3},  // R3 clock source
    '{1'b0,1'b0,1'b1,1'b0,8'h61, 3'd0,1'b1,4'd5,4'hF,1'b1,1'b0,1'b0, 8'd8},  // R8 set beats clear
    '{1'b1,1'b1,1'b0,1'b0,8'h00, 3'd0,1'b0,4'd2,4'hF,1'b1,1'b0,1'b0, 8'd4}   // R4 wake from slow run
  };

  task automatic check_all(input int req, input int row, input logic [2:0] m, input logic lo,
                           input logic [3:0] dv, input logic [3:0] g, input logic rj,
                           input logic ck, input logic lk);
    logic [14:0] got;
    logic [14:0] exp;
    got = {mode_o, lo_state_o, div_o, gate_en_o, rejected_o, clksrc_o, lock_o};
    exp = {m, lo, dv, g, rj, ck, lk};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d row %0d: got mode=%0d lo=%0b div=%0d gate=%b rej=%0b clk=%0b lock=%0b exp mode=%0d lo=%0b div=%0d gate=%b rej=%0b clk=%0b lock=%0b",
               req, row, mode_o, lo_state_o, div_o, gate_en_o, rejected_o, clksrc_o, lock_o,
               m, lo, dv, g, rj, ck, lk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all(1, -1, 3'd0, 1'b0, 4'd1, 4'hF, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      exit_i    = VT[i].ex;
      pwr_en_i  = VT[i].pe;
      wr_en_i   = VT[i].we;
      wr_sel_i  = VT[i].sel;
      wr_data_i = VT[i].d;
      @(negedge clk);
      check_all(int'(VT[i].req), i, VT[i].m, VT[i].lo, VT[i].dv, VT[i].g, VT[i].rj, VT[i].ck, VT[i].lk);
    end
    exit_i  = 1'b0;
    wr_en_i = 1'b0;

    // R7 doze keeps clock source; first set clksrc=1 in run, then write 0 in doze
    pwr_en_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 1'b0;
    wr_data_i = 8'h50;                      // clear flag, clksrc=1
    @(negedge clk);
    wr_data_i = 8'h11;                      // doze, clksrc stays 1
    @(negedge clk);
    wr_data_i = 8'h04;                      // power-down request and clksrc=0, both ignored
    @(negedge clk);
    check_all(7, 100, 3'd1, 1'b0, 4'd2, 4'hE, 1'b0, 1'b1, 1'b0);
    wr_en_i = 1'b0;

    // R1 reset from doze with a write pending
    rst = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h28;
    repeat (2) @(negedge clk);
    rst = 1'b0; wr_en_i = 1'b0;
    check_all(1, 101, 3'd0, 1'b0, 4'd1, 4'hF, 1'b0, 1'b0, 1'b0);

    // R9 divider values restored by reset: slow substate shows 8
    wr_en_i = 1'b1; wr_data_i = 8'h20;
    @(negedge clk);
    wr_en_i = 1'b0;
    check_all(9, 102, 3'd0, 1'b1, 4'd8, 4'hF, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: got no completion exp completion within 5000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule